// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block controls the transfers of one DMA channel. A host programs a start address, a transfer count and a mode word through a small register write port. When a peripheral asks for service, the block requests the system bus from the host and waits for the host to grant it. It then runs fly-by transfer cycles. In each cycle it drives the memory address, one memory strobe and the acknowledge to the peripheral, while the data moves directly between the peripheral and memory.

Four service policies are available: one transfer per request, a burst for as long as the peripheral keeps requesting, a full burst that runs to the end of the count, and a pass-through mode that chains a downstream controller's request and grant onto this channel's pins. The channel flags the last transfer of its count to the peripheral. An external end-of-process input can also stop a transfer sequence. With auto-initialization enabled, the working address and count are reloaded from the programmed start values at every end of process, with no help from the host.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, hrq_o, dack_o, tc_o, mem_rd_o, mem_wr_o and addr_o are low, the mode is single, and the channel is disarmed, so a held dreq_i raises no bus request.
- R2: A write with wr_sel_i=0 sets the start address and the working address. wr_sel_i=1 sets the start count and the working count, and arms the channel. The count value is written as the number of transfers minus one. wr_sel_i=2 writes the mode word: bits [1:0] select single=00, demand=01, block=10, cascade=11; bit 2 selects address decrement; bit 3 enables auto-initialization; bit 4 selects memory read (1) or memory write (0).
- R3: An armed channel with dreq_i high raises hrq_o. Transfers happen only while hlda_i is high. Each transfer is one cycle with dack_o high, addr_o set to the working address, and exactly one strobe high: mem_rd_o or mem_wr_o as chosen by mode bit 4.
- R4: In single mode each grant gives one transfer, and hrq_o is low the cycle after it. If dreq_i drops before the acknowledge, the request is cancelled with no transfer.
- R5: In block mode dreq_i need only last until the first acknowledge. Transfers then run in consecutive cycles until the count ends or an end of process occurs.
- R6: In demand mode transfers continue while dreq_i is high. When dreq_i goes low the bus is released, and the working address and count are kept for the next request.
- R7: Each transfer decrements the working count. It also steps the working address by one, up or down, wrapping modulo 2^AW.
- R8: tc_o is high, together with dack_o, on the transfer made when the working count is zero. hrq_o is low in the cycle after that transfer.
- R9: If eop_i is high at the clock edge that completes a transfer, that transfer is the last one of the sequence, and tc_o stays low.
- R10: At the count end or at an external end of process, auto-initialization reloads the working address and count from the start values and keeps the channel armed. Without auto-initialization the channel disarms and ignores dreq_i until the count is written again. A drop of dreq_i in demand mode never reloads.
- R11: In cascade mode hrq_o follows dreq_i and dack_o follows hlda_i. addr_o, mem_rd_o, mem_wr_o and tc_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 count, 2 mode |
| wr_data_i | input | AW | Register write data |
| dreq_i | input | 1 | Peripheral service request |
| dack_o | output | 1 | Acknowledge to the peripheral, one per transfer |
| hrq_o | output | 1 | Bus request to the host |
| hlda_i | input | 1 | Bus grant from the host |
| eop_i | input | 1 | External end of process, active high |
| tc_o | output | 1 | Count end marker on the final transfer |
| addr_o | output | AW | Memory address of the current transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
A working address or count that went wrong shows up on addr_o at the very next acknowledge. A wrong count also moves tc_o to a different transfer within the same sequence. A wrong sequencer state shows up as an extra or missing transfer, or as hrq_o failing to drop one cycle after a single-mode or final transfer. A bad reload or disarm decision is seen at the start of the following sequence: either the first address differs from the programmed start, or a held request draws transfers that should not happen. Every scenario therefore checks the full address list, the tc_o position and the number of bus tenures.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE  = 2'b00,
    XM_DEMAND  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       mem_rd;     // 1: memory read, 0: memory write
    logic       auto_init;
    logic       dec;        // address decrement
    xfer_mode_e mode;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_XFER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          xfer_i,
  input  logic          end_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          cnt_zero_o,
  output mode_t         mode_o,
  output logic          armed_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [AW-1:0] addr_step;
  mode_t         mode_q;
  logic          armed_q;

  assign addr_step = mode_q.dec ? cur_addr_q - ONE : cur_addr_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
      armed_q     <= 1'b0;
    end else if (wr_en_i) begin
      // host writes win over a transfer in the same cycle
      unique case (wr_sel_i)
        SEL_ADDR: begin
          base_addr_q <= wr_data_i;
          cur_addr_q  <= wr_data_i;
        end
        SEL_CNT: begin
          base_cnt_q <= wr_data_i;
          cur_cnt_q  <= wr_data_i;
          armed_q    <= 1'b1;
        end
        SEL_MODE: mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
        default: ;
      endcase
    end else if (xfer_i) begin
      if (end_i && mode_q.auto_init) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        cur_addr_q <= addr_step;
        cur_cnt_q  <= cur_cnt_q - ONE;
        if (end_i) armed_q <= 1'b0;
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cnt_zero_o = (cur_cnt_q == '0);
  assign mode_o     = mode_q;
  assign armed_o    = armed_q;

  // R7: count steps down by one on a plain transfer
  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !wr_en_i && !end_i) |=> cur_cnt_q == $past(cur_cnt_q) - ONE);

  // R10: auto-init restores the start address
  a_r10_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && end_i && mode_q.auto_init && !wr_en_i) |=> cur_addr_q == base_addr_q);

  // R10: without auto-init the channel disarms
  a_r10_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && end_i && !mode_q.auto_init && !wr_en_i) |=> !armed_q);

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xfer_mode_e mode_i,
  input  logic       armed_i,
  input  logic       cnt_zero_i,
  input  logic       dreq_i,
  input  logic       hlda_i,
  input  logic       eop_i,
  output logic       hrq_o,
  output logic       dack_o,
  output logic       tc_o,
  output logic       end_o
);

  seq_state_e state_q, state_d;

  assign dack_o = (state_q == S_XFER) && hlda_i;
  assign tc_o   = dack_o && cnt_zero_i;
  assign end_o  = dack_o && (cnt_zero_i || eop_i);
  assign hrq_o  = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:
        if (armed_i && mode_i != XM_CASCADE && dreq_i) state_d = S_WAIT;
      S_WAIT:
        if (!armed_i || (mode_i != XM_BLOCK && !dreq_i)) state_d = S_IDLE;
        else if (hlda_i)                                   state_d = S_XFER;
      S_XFER:
        if (!hlda_i)    state_d = S_WAIT;
        else if (end_o) state_d = S_IDLE;
        else begin
          unique case (mode_i)
            XM_BLOCK:  state_d = S_XFER;
            XM_DEMAND: state_d = dreq_i ? S_XFER : S_IDLE;
            default:   state_d = S_IDLE;
          endcase
        end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // R3: no acknowledge without the bus grant
  a_r3_dack_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> hlda_i);

  // R4: single mode hands the bus back after one transfer
  a_r4_single_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode_i == XM_SINGLE) |=> !hrq_o);

  // R8: request drops the cycle after the final transfer
  a_r8_hrq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !hrq_o);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          dreq_i,
  output logic          dack_o,
  output logic          hrq_o,
  input  logic          hlda_i,
  input  logic          eop_i,
  output logic          tc_o,
  output logic [AW-1:0] addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o
);

  mode_t         mode;
  logic          armed, cnt_zero, cascade, xfer;
  logic          fsm_hrq, fsm_dack, fsm_tc, fsm_end;
  logic [AW-1:0] cur_addr;

  assign cascade = (mode.mode == XM_CASCADE);
  assign xfer    = fsm_dack && !cascade;

  dma_chan_regs #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .xfer_i     (xfer),
    .end_i      (fsm_end),
    .cur_addr_o (cur_addr),
    .cnt_zero_o (cnt_zero),
    .mode_o     (mode),
    .armed_o    (armed)
  );

  dma_chan_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode.mode),
    .armed_i    (armed),
    .cnt_zero_i (cnt_zero),
    .dreq_i     (dreq_i),
    .hlda_i     (hlda_i),
    .eop_i      (eop_i),
    .hrq_o      (fsm_hrq),
    .dack_o     (fsm_dack),
    .tc_o       (fsm_tc),
    .end_o      (fsm_end)
  );

  // cascade: pins chain a downstream controller, no local bus cycle
  assign hrq_o    = cascade ? dreq_i : fsm_hrq;
  assign dack_o   = cascade ? hlda_i : fsm_dack;
  assign tc_o     = xfer && fsm_tc;
  assign addr_o   = xfer ? cur_addr : '0;
  assign mem_rd_o = xfer && mode.mem_rd;
  assign mem_wr_o = xfer && !mode.mem_rd;

  // R11: cascade drives no bus cycle
  a_r11_cascade_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade |-> (!mem_rd_o && !mem_wr_o && !tc_o && addr_o == '0));

  // R8: terminal marker only with an acknowledge
  a_r8_tc_with_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> dack_o);

  // R3: at most one strobe per cycle
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_rd_o, mem_wr_o}) <= 1);

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic          dreq = 1'b0;
  logic          hlda = 1'b0;
  logic          eop = 1'b0;
  logic          dack, hrq, tc, mem_rd, mem_wr;
  logic [AW-1:0] addr;

  always #5 clk = ~clk;

  dma_chan_seq #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .dreq_i(dreq), .dack_o(dack), .hrq_o(hrq),
    .hlda_i(hlda), .eop_i(eop), .tc_o(tc), .addr_o(addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr)
  );

  // host grants the bus one cycle after the request
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) hlda <= 1'b0;
    else         hlda <= hrq;

  int n_checks = 0;
  int n_fail   = 0;

  // transfer log
  logic [AW-1:0] lg_addr [64];
  logic          lg_tc   [64];
  logic          lg_rd   [64];
  logic          lg_wr   [64];
  int            n_x = 0;
  int            n_burst = 0;
  int            n_hrq_after_tc = 0;
  logic          prev_hrq = 1'b0;
  logic          prev_tc = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_tc && hrq) n_hrq_after_tc++;
      if (prev_hrq && !hrq) n_burst++;
      if (dack) begin
        lg_addr[n_x % 64] = addr;
        lg_tc[n_x % 64]   = tc;
        lg_rd[n_x % 64]   = mem_rd;
        lg_wr[n_x % 64]   = mem_wr;
        n_x++;
      end
      prev_hrq = hrq;
      prev_tc  = tc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_ch(input logic [AW-1:0] a, input int n, input logic [4:0] m);
    wr_reg(2'd2, AW'(m));
    wr_reg(2'd0, a);
    wr_reg(2'd1, AW'(n - 1));
  endtask

  task automatic wait_x(input int target);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (n_x >= target) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // R1
  task automatic t_reset;
    idle(1);
    check(!hrq && !dack && !tc, "R1 handshake idle", {hrq, dack, tc}, 0);
    check(!mem_rd && !mem_wr && addr == '0, "R1 bus idle", {mem_rd, mem_wr, addr}, 0);
    dreq = 1'b1;
    idle(6);
    check(!hrq && n_x == 0, "R1 disarmed ignores dreq", n_x, 0);
    dreq = 1'b0;
    idle(2);
  endtask

  // R4 cancel, R4/R7/R8/R10 single mode
  task automatic t_single;
    int b0, bb, h0;
    program_ch(16'h0777, 1, 5'b00000);
    b0 = n_x;
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    idle(8);
    check(n_x == b0, "R4 withdrawn request cancelled", n_x - b0, 0);

    program_ch(16'h1000, 3, 5'b00000);  // single, inc, mem write, R2
    b0 = n_x; bb = n_burst; h0 = n_hrq_after_tc;
    dreq = 1'b1;
    idle(40);
    dreq = 1'b0;
    idle(4);
    check(n_x - b0 == 3, "R10 single ends without auto-init", n_x - b0, 3);
    check(n_burst - bb == 3, "R4 one transfer per grant", n_burst - bb, 3);
    for (int i = 0; i < 3; i++) begin
      check(lg_addr[(b0+i)%64] == AW'(16'h1000 + i), "R7 single address up",
            lg_addr[(b0+i)%64], 16'h1000 + i);
      check(lg_tc[(b0+i)%64] == (i == 2), "R8 tc on last", lg_tc[(b0+i)%64], i == 2);
      check(lg_wr[(b0+i)%64] && !lg_rd[(b0+i)%64], "R3 write strobe",
            {lg_rd[(b0+i)%64], lg_wr[(b0+i)%64]}, 1);
    end
    check(n_hrq_after_tc == h0, "R8 hrq low after tc", n_hrq_after_tc - h0, 0);
  endtask

  // R5/R7/R10 block decrement, memory read
  task automatic t_block_dec;
    int b0, bb;
    program_ch(16'h0005, 4, 5'b10110);
    b0 = n_x; bb = n_burst;
    @(negedge clk); dreq = 1'b1;
    wait_x(b0 + 1);
    dreq = 1'b0;
    idle(20);
    check(n_x - b0 == 4, "R5 block runs to count end", n_x - b0, 4);
    check(n_burst - bb == 1, "R5 single bus tenure", n_burst - bb, 1);
    for (int i = 0; i < 4; i++) begin
      check(lg_addr[(b0+i)%64] == AW'(5 - i), "R7 block address down",
            lg_addr[(b0+i)%64], 5 - i);
      check(lg_rd[(b0+i)%64] && !lg_wr[(b0+i)%64], "R3 read strobe",
            {lg_rd[(b0+i)%64], lg_wr[(b0+i)%64]}, 2);
    end
    check(lg_tc[(b0+3)%64] && !lg_tc[(b0+2)%64], "R8 tc on fourth", lg_tc[(b0+3)%64], 1);
    dreq = 1'b1;
    idle(10);
    dreq = 1'b0;
    check(n_x - b0 == 4 && !hrq, "R10 disarmed after end", n_x - b0, 4);
  endtask

  // R7 wrap
  task automatic t_wrap;
    int b0;
    program_ch(16'hFFFE, 3, 5'b00010);
    b0 = n_x;
    @(negedge clk); dreq = 1'b1;
    wait_x(b0 + 1);
    dreq = 1'b0;
    idle(10);
    check(n_x - b0 == 3, "R7 wrap count", n_x - b0, 3);
    check(lg_addr[(b0+1)%64] == 16'hFFFF, "R7 wrap top", lg_addr[(b0+1)%64], 16'hFFFF);
    check(lg_addr[(b0+2)%64] == 16'h0000, "R7 wrap to zero", lg_addr[(b0+2)%64], 0);
  endtask

  // R6/R10 demand with auto-init
  task automatic t_demand;
    int b0, bb;
    program_ch(16'h0200, 10, 5'b01001);
    b0 = n_x; bb = n_burst;
    @(negedge clk); dreq = 1'b1;
    wait_x(b0 + 3);
    dreq = 1'b0;
    idle(10);
    check(n_x - b0 == 3, "R6 dreq low stops demand", n_x - b0, 3);
    check(!hrq, "R6 bus released", hrq, 0);
    dreq = 1'b1;
    wait_x(b0 + 11);
    dreq = 1'b0;
    idle(10);
    check(n_x - b0 == 11, "R6 demand resumes", n_x - b0, 11);
    check(n_burst - bb >= 2, "R6 separate tenures", n_burst - bb, 2);
    for (int i = 0; i < 10; i++)
      check(lg_addr[(b0+i)%64] == AW'(16'h0200 + i), "R10 no reload on dreq drop",
            lg_addr[(b0+i)%64], 16'h0200 + i);
    check(lg_tc[(b0+9)%64] && !lg_tc[(b0+2)%64], "R8 demand tc", lg_tc[(b0+9)%64], 1);
    check(lg_addr[(b0+10)%64] == 16'h0200, "R10 reload after tc", lg_addr[(b0+10)%64], 16'h0200);
  endtask

  // R9/R10 external end of process in block mode
  task automatic t_eop;
    int b0;
    program_ch(16'h0040, 8, 5'b01010);
    b0 = n_x;
    @(negedge clk); dreq = 1'b1;
    wait_x(b0 + 1);
    dreq = 1'b0;
    wait_x(b0 + 2);
    eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    idle(10);
    check(n_x - b0 == 2, "R9 eop ends sequence", n_x - b0, 2);
    check(!lg_tc[b0%64] && !lg_tc[(b0+1)%64], "R9 no tc on eop", lg_tc[(b0+1)%64], 0);
    @(negedge clk); dreq = 1'b1;
    wait_x(b0 + 3);
    dreq = 1'b0;
    idle(20);
    check(n_x - b0 == 10, "R10 full reload count", n_x - b0, 10);
    check(lg_addr[(b0+2)%64] == 16'h0040, "R10 reload after eop", lg_addr[(b0+2)%64], 16'h0040);
    check(lg_addr[(b0+9)%64] == 16'h0047 && lg_tc[(b0+9)%64], "R8 tc after reload",
          lg_addr[(b0+9)%64], 16'h0047);
  endtask

  // R11 cascade
  task automatic t_cascade;
    wr_reg(2'd2, AW'(5'b00011));
    wr_reg(2'd1, AW'(3));
    @(negedge clk); dreq = 1'b1;
    #1;
    check(hrq, "R11 hrq follows dreq", hrq, 1);
    @(negedge clk); #1;
    check(dack, "R11 dack follows hlda", dack, 1);
    check(!mem_rd && !mem_wr && !tc && addr == '0, "R11 no bus cycle",
          {mem_rd, mem_wr, tc, addr}, 0);
    dreq = 1'b0;
    #1;
    check(!hrq, "R11 hrq drops with dreq", hrq, 0);
    idle(3);
    check(!dack, "R11 dack drops with hlda", dack, 0);
  endtask

  bit done = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_block_dec();
    t_wrap();
    t_demand();
    t_eop();
    t_cascade();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule